// File: doc/BRIEF.md
# Smoothed Dual-Path PLL Feedback Divider

This block is the digital feedback divider of a frequency-synthesizing PLL whose output clock is frequency modulated only while a label bit is 1. Running on the VCO clock, it keeps two dividers in step. One divides by a constant ratio N. The other walks a four-segment ratio pattern: N, then N+a, then N again, then N−a. One full pattern lasts exactly as long as four constant-ratio periods. The selected divider's square wave goes out as the feedback signal for an external XOR phase detector. The analog XOR, loop filter and VCO sit outside the block, and so does the flop that retimes the frame data.

The label bit does not drive the path select directly. A falling edge of a synchronous clock with a period of one full pattern samples it, and the sample is accepted only while the variable divider is in the first ratio-N segment of its pattern. In that segment both divider counters hold identical values. The select therefore changes only at a point where the two feedback waveforms coincide, and the loop sees no phase step. N and a are run-time inputs. They are clamped to the legal range and adopted only at the boundary between two patterns, so both dividers always restart together.

Top module: `fbd_smooth_div`

## Requirements
- R1: While rst_ni is low, fb_o and mod_o are 0. After release, both dividers start at count 0 at the start of a pattern, and the constant path is selected.
- R2: With mod_o = 0, fb_o is a square wave whose rising edges are N clock cycles apart.
- R3: With mod_o = 1, the spacing between successive rising edges of fb_o cycles through N, N+a, N, N−a and repeats.
- R4: The path select (mod_o) takes the value of label_i only on a clock edge where sync_clk_i is seen falling, meaning it was 1 on the previous edge and is 0 now. A label change without such a fall has no effect on mod_o.
- R5: A sync_clk_i fall is ignored unless the variable divider is in the first ratio-N segment of its pattern. For a constant N, that segment is cycles 0 to N−1 of each 4N-cycle pattern counted from reset release.
- R6: New values on ratio_n_i and depth_a_i take effect only at the start of the next pattern. Segments already under way keep the old values.
- R7: N is clamped to the range 4 to MAX_N, where MAX_N = floor((2^W−1)·4/5). a is clamped to the range 1 to floor(N/4). For example, a = 0 behaves as 1, N = 12 with a = 5 behaves as a = 3, and N = 2 behaves as N = 4.
- R8: When the select changes, the two divider counters are equal, so the feedback waveform continues without a phase step.
- R9: In each divider period of ratio r, fb_o is high for floor(r/2) cycles, beginning at the period's first cycle and delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_clk_i | input | 1 | Synchronous clock, one period per divider pattern; its falling edge samples the label |
| label_i | input | 1 | Label bit: 1 requests modulation |
| ratio_n_i | input | W | Center division ratio N |
| depth_a_i | input | W | Modulation depth a |
| fb_o | output | 1 | Divided feedback square wave to the phase detector |
| mod_o | output | 1 | Current path select: 1 means the variable divider drives fb_o |

## Verification
The assertions assume that sync_clk_i is synchronous to clk_i, because the block samples it as plain data. They also assume that ratio_n_i and depth_a_i may change at any time. Neither assumption constrains the pattern or the clamp checks. The stimulus holds each configuration for several whole patterns before it measures edge spacing. It toggles sync_clk_i every other cycle until a fall lands in the acceptance window, and it places single falls at known pattern offsets counted from reset release when it probes the window gate.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [1:0] {
    SEG_N0 = 2'd0,
    SEG_UP = 2'd1,
    SEG_N1 = 2'd2,
    SEG_DN = 2'd3
  } seg_e;
endpackage

// File: rtl/fbd_cfg.sv
module fbd_cfg #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEF_N = 10,
  parameter int unsigned DEF_A = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] n_o,
  output logic [W-1:0] a_o
);
  localparam int unsigned MAX_N = ((2**W - 1) * 4) / 5;
  localparam logic [W-1:0] MAX_NV = W'(MAX_N);
  localparam logic [W-1:0] MIN_NV = W'(4);

  logic [W-1:0] n_c, a_c, a_max;

  always_comb begin
    if (n_i < MIN_NV)       n_c = MIN_NV;
    else if (n_i > MAX_NV)  n_c = MAX_NV;
    else                    n_c = n_i;
    a_max = n_c >> 2;
    if (a_i == '0)          a_c = W'(1);
    else if (a_i > a_max)   a_c = a_max;
    else                    a_c = a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o <= W'(DEF_N);
      a_o <= W'(DEF_A);
    end else if (load_i) begin
      n_o <= n_c;
      a_o <= a_c;
    end
  end
endmodule

// File: rtl/fbd_var_div.sv
module fbd_var_div
  import fbd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] a_i,
  output seg_e         seg_o,
  output logic [W-1:0] cnt_o,
  output logic         seq_end_o,
  output logic         sq_o
);
  seg_e         seg_q;
  logic [W-1:0] cnt_q, ratio, last_cnt;
  logic         last;

  always_comb begin
    unique case (seg_q)
      SEG_UP:  ratio = n_i + a_i;
      SEG_DN:  ratio = n_i - a_i;
      default: ratio = n_i;
    endcase
    last_cnt = ratio - W'(1);
    last     = (cnt_q == last_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_N0;
      cnt_q <= '0;
    end else if (last) begin
      seg_q <= seg_e'(seg_q + 2'd1);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign seg_o     = seg_q;
  assign cnt_o     = cnt_q;
  assign seq_end_o = last && (seg_q == SEG_DN);
  assign sq_o      = (cnt_q < (ratio >> 1));
endmodule

// File: rtl/fbd_fix_div.sv
module fbd_fix_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  output logic [W-1:0] cnt_o,
  output logic         sq_o
);
  logic [W-1:0] cnt_q, last_cnt;

  assign last_cnt = n_i - W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q == last_cnt) cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
  assign sq_o  = (cnt_q < (n_i >> 1));
endmodule

// File: rtl/fbd_path_sel.sv
module fbd_path_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clk_i,
  input  logic label_i,
  input  logic window_i,
  input  logic sq_fix_i,
  input  logic sq_var_i,
  output logic sync_q_o,
  output logic sel_o,
  output logic fb_o
);
  logic sync_q, sel_q, fb_q, sync_fall;

  assign sync_fall = sync_q & ~sync_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      sel_q  <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      sync_q <= sync_clk_i;
      // label is retimed only inside the aligned window
      if (sync_fall && window_i) sel_q <= label_i;
      fb_q <= sel_q ? sq_var_i : sq_fix_i;
    end
  end

  assign sync_q_o = sync_q;
  assign sel_o    = sel_q;
  assign fb_o     = fb_q;
endmodule

// File: rtl/fbd_smooth_div.sv
module fbd_smooth_div
  import fbd_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEF_N = 10,
  parameter int unsigned DEF_A = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_clk_i,
  input  logic         label_i,
  input  logic [W-1:0] ratio_n_i,
  input  logic [W-1:0] depth_a_i,
  output logic         fb_o,
  output logic         mod_o
);
  logic [W-1:0] n_w, a_w, cnt_v_w, cnt_f_w;
  seg_e         seg_w;
  logic         seq_end_w, sq_v_w, sq_f_w, sync_q_w, window_w;

  fbd_cfg #(.W(W), .DEF_N(DEF_N), .DEF_A(DEF_A)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seq_end_w),
    .n_i    (ratio_n_i),
    .a_i    (depth_a_i),
    .n_o    (n_w),
    .a_o    (a_w)
  );

  fbd_var_div #(.W(W)) u_var (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .n_i       (n_w),
    .a_i       (a_w),
    .seg_o     (seg_w),
    .cnt_o     (cnt_v_w),
    .seq_end_o (seq_end_w),
    .sq_o      (sq_v_w)
  );

  fbd_fix_div #(.W(W)) u_fix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (n_w),
    .cnt_o  (cnt_f_w),
    .sq_o   (sq_f_w)
  );

  assign window_w = (seg_w == SEG_N0);

  fbd_path_sel u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clk_i (sync_clk_i),
    .label_i    (label_i),
    .window_i   (window_w),
    .sq_fix_i   (sq_f_w),
    .sq_var_i   (sq_v_w),
    .sync_q_o   (sync_q_w),
    .sel_o      (mod_o),
    .fb_o       (fb_o)
  );
endmodule

// File: rtl/fbd_smooth_div_chk.sv
module fbd_smooth_div_chk
  import fbd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sync_clk_i,
  input logic         mod_o,
  input logic         fb_o,
  input logic         sync_q_w,
  input seg_e         seg_w,
  input logic [W-1:0] cnt_v_w,
  input logic [W-1:0] cnt_f_w,
  input logic [W-1:0] n_w,
  input logic [W-1:0] a_w,
  input logic         seq_end_w,
  input logic         sq_v_w,
  input logic         sq_f_w
);
  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!fb_o && !mod_o);
  end

  assert_sel_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_o) |-> $past(sync_q_w && !sync_clk_i));

  assert_sel_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_o) |-> $past(seg_w == SEG_N0));

  assert_seamless_switch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_o) |-> $past(cnt_v_w == cnt_f_w && sq_v_w == sq_f_w));

  assert_cfg_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(n_w) || !$stable(a_w)) |-> $past(seq_end_w));

  assert_cfg_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_w >= W'(4)) && (a_w >= W'(1)) && (a_w <= (n_w >> 2)));

  assert_restart_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end_w |=> (seg_w == SEG_N0 && cnt_v_w == '0 && cnt_f_w == '0));

  assert_fix_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_f_w < n_w);
endmodule

bind fbd_smooth_div fbd_smooth_div_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_clk_i (sync_clk_i),
  .mod_o      (mod_o),
  .fb_o       (fb_o),
  .sync_q_w   (sync_q_w),
  .seg_w      (seg_w),
  .cnt_v_w    (cnt_v_w),
  .cnt_f_w    (cnt_f_w),
  .n_w        (n_w),
  .a_w        (a_w),
  .seq_end_w  (seq_end_w),
  .sq_v_w     (sq_v_w),
  .sq_f_w     (sq_f_w)
);

// File: tb/tb_fbd_smooth_div.sv
`timescale 1ns/1ps
module tb_fbd_smooth_div;
  localparam int W = 8;
  localparam int NV = 7;
  // {label, n, a, exp_lo, exp_hi}
  localparam logic [39:0] VEC [NV] = '{
    {8'd0, 8'd10, 8'd1, 8'd10, 8'd10},
    {8'd1, 8'd10, 8'd1, 8'd9,  8'd11},
    {8'd1, 8'd12, 8'd5, 8'd9,  8'd15},
    {8'd1, 8'd10, 8'd0, 8'd9,  8'd11},
    {8'd1, 8'd2,  8'd1, 8'd3,  8'd5 },
    {8'd0, 8'd16, 8'd4, 8'd16, 8'd16},
    {8'd1, 8'd20, 8'd2, 8'd18, 8'd22}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, sync_clk_i = 1'b1, label_i = 1'b0;
  logic [W-1:0] ratio_n_i = 8'd10, depth_a_i = 8'd1;
  logic fb_o, mod_o;
  int tcnt = 0, checks = 0, errors = 0;
  int iv [8];

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) tcnt <= 0;
    else         tcnt <= tcnt + 1;
  end

  fbd_smooth_div #(.W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_clk_i(sync_clk_i), .label_i(label_i),
    .ratio_n_i(ratio_n_i), .depth_a_i(depth_a_i), .fb_o(fb_o), .mod_o(mod_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_t(input int t);
    while (tcnt != t) @(negedge clk_i);
  endtask

  task automatic wait_rise(output int t);
    logic p;
    p = fb_o;
    forever begin
      @(negedge clk_i);
      if (fb_o && !p) break;
      p = fb_o;
    end
    t = tcnt;
  endtask

  task automatic capture(input int cnt);
    int t0, t1;
    wait_rise(t0);
    for (int i = 0; i < cnt; i++) begin
      wait_rise(t1);
      iv[i] = t1 - t0;
      t0 = t1;
    end
  endtask

  // toggles the sync clock long enough for a fall to land in the window
  task automatic set_label(input logic v);
    label_i = v;
    for (int i = 0; i < 220; i++) begin
      @(negedge clk_i);
      sync_clk_i = ~sync_clk_i;
    end
    @(negedge clk_i);
    sync_clk_i = 1'b1;
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ts, hi, k, lo_e, hi_e, n_e;
    bit ok;
    repeat (3) @(negedge clk_i);
    chk(fb_o == 1'b0, "R1 fb_o in reset", fb_o, 0);
    chk(mod_o == 1'b0, "R1 mod_o in reset", mod_o, 0);
    rst_ni = 1'b1;

    // R4/R5 at known offsets from reset release (N=10, pattern 40)
    wait_t(2);  label_i = 1'b1;
    wait_t(14); chk(mod_o == 1'b0, "R4 label without sync fall", mod_o, 0);
    wait_t(15); sync_clk_i = 1'b0;
    wait_t(16); sync_clk_i = 1'b1;
    wait_t(18); chk(mod_o == 1'b0, "R5 fall outside window", mod_o, 0);
    wait_t(42); sync_clk_i = 1'b0;
    wait_t(43); sync_clk_i = 1'b1;
    wait_t(44); chk(mod_o == 1'b1, "R5 fall inside window", mod_o, 1);

    // vector table: R2 R3 R7 R9
    for (int v = 0; v < NV; v++) begin
      ratio_n_i = VEC[v][31:24];
      depth_a_i = VEC[v][23:16];
      lo_e = int'(VEC[v][15:8]);
      hi_e = int'(VEC[v][7:0]);
      n_e  = (lo_e + hi_e) / 2;
      set_label(VEC[v][32]);
      repeat (200) @(negedge clk_i);
      chk(mod_o == VEC[v][32], "R4 mode after label", mod_o, int'(VEC[v][32]));
      capture(8);
      if (!VEC[v][32]) begin
        for (int i = 0; i < 8; i++)
          chk(iv[i] == n_e, "R2 fixed spacing", iv[i], n_e);
        wait_rise(ts);
        hi = 1;
        while (fb_o) begin @(negedge clk_i); if (fb_o) hi++; end
        chk(hi == n_e / 2, "R9 high time", hi, n_e / 2);
      end else begin
        k = -1;
        for (int i = 0; i < 4; i++) if (iv[i] == hi_e) k = i;
        ok = (k >= 0);
        if (ok) ok = (iv[k+1] == n_e) && (iv[k+2] == lo_e) && (iv[k+3] == n_e)
                  && (iv[k+4] == hi_e);
        chk(ok, v == 1 || v == 6 ? "R3 pattern" : "R7 clamped pattern",
            (k >= 0) ? iv[(k + 2)] : -1, lo_e);
      end
    end

    // R6: change N mid-pattern
    ratio_n_i = 8'd10; depth_a_i = 8'd1;
    set_label(1'b1);
    repeat (200) @(negedge clk_i);
    k = 0;
    begin
      int t0, t1;
      wait_rise(t0);
      for (int g = 0; g < 20; g++) begin
        wait_rise(t1);
        if (t1 - t0 == 9) break;
        t0 = t1;
      end
    end
    fork
      begin repeat (15) @(negedge clk_i); ratio_n_i = 8'd12; end
      begin
        int t0, t1;
        t0 = tcnt;
        for (int i = 0; i < 8; i++) begin
          wait_rise(t1);
          iv[i] = t1 - t0;
          t0 = t1;
        end
      end
    join
    begin
      int exp6 [8] = '{10, 11, 10, 9, 12, 13, 12, 11};
      for (int i = 0; i < 8; i++)
        chk(iv[i] == exp6[i], "R6 change at boundary", iv[i], exp6[i]);
    end

    // R8: switching back leaves constant spacing
    set_label(1'b0);
    repeat (200) @(negedge clk_i);
    capture(4);
    for (int i = 0; i < 4; i++)
      chk(iv[i] == 12, "R8 after switch back", iv[i], 12);
    chk(mod_o == 1'b0, "R8 mode after switch back", mod_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule